// File: doc/BRIEF.md
# Variable-Width Operand Unpacker

This block sits between the 32-bit read port of an operand buffer and a row of processing-engine lanes. It holds one buffer word and then hands it out as a series of narrow fields. The field width is picked at run time from 1, 2, 4, 8 or 16 bits. Each cycle it presents up to `LANES` fields, each sign- or zero-extended to 16 bits. A word that holds more fields than there are lanes is served over several cycles, so the buffer's data array is read only once per word, however narrow the operands are.

The block asks the buffer for a new word with a request strobe. The word comes back some cycles later, marked by a data-valid strobe. Width and sign mode are captured when a word is loaded. If the width selection changes while a word is still being served, the rest of that word is dropped and a fresh word is requested under the new width.

Top module: `operand_unpacker`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is 0, `lane_valid` is 0, `lane_data` is 0 and `rd_req` is 1, because the holding register starts empty.
- R2: `width_sel` code c in 0..4 selects fields of 2^c bits (1, 2, 4, 8, 16). Codes 5, 6 and 7 behave exactly like code 4 (16 bits).
- R3: Fields are taken from the least significant end. Field i of a word occupies bits [i*w +: w]. In serving cycle g (counting from 0 after the load), lane L carries field g*LANES+L, in bits [L*16 +: 16] of `lane_data`.
- R4: A word with F = 32/w fields is served over ceil(F/LANES) consecutive cycles. In each cycle, exactly the lanes whose field index is below F have `lane_valid` set. Every lane without `lane_valid` reads as 0, and all lanes are 0 while `out_valid` is low.
- R5: With `sign_en` = 1 at load time, each field is sign-extended to 16 bits. Otherwise it is zero-extended. A change of `sign_en` while a word is being served does not affect that word.
- R6: `rd_req` is high for exactly one cycle per word. That cycle is the one in which the last group of the held word is issued, or the cycle in which a word is discarded, or the first cycle after reset. It is never high two cycles in a row.
- R7: No field is issued between a request and the arrival of the word. `out_valid` goes high in the cycle after `rd_valid` is accepted, and not before.
- R8: A `rd_valid` pulse that arrives while no request is outstanding is ignored. The held word goes on being served unchanged.
- R9: If the normalised `width_sel` differs from the width of the held word, the following happens in the same cycle: `out_valid` and all `lane_valid` go low, and `rd_req` goes high. The remainder of the word is discarded, and the next word is served with the new width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 3 | Field width code (R2) |
| sign_en | input | 1 | 1: sign-extend fields, 0: zero-extend |
| rd_valid | input | 1 | Buffer word valid on `rd_data` |
| rd_data | input | 32 | Buffer read data |
| rd_req | output | 1 | Request for the next buffer word |
| out_valid | output | 1 | Lanes carry an issued group this cycle |
| lane_valid | output | 4 | Per-lane field valid |
| lane_data | output | 64 | Four 16-bit extended fields, lane 0 in the low bits |

## Verification
The hardest situation to reach is a disturbance in the middle of a word. This can be a stray `rd_valid` pulse, a flip of `sign_en`, or a width change that arrives while a narrow word still has groups left to serve. Ordinary request-and-serve traffic never produces any of these. The stimulus therefore walks a modelled buffer word by word, with random data, widths, sign modes and response latencies. It also picks, at random, a group inside the word at which to inject a junk read, flip the sign mode, or change the width. The directed cases force the same events on 1-bit words, which have eight groups, so that the disturbance always falls in the middle of a word.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

   // number of issue cycles needed for one word at a given width code
   function automatic int unsigned unpk_groups(input int unsigned word_w,
                                               input int unsigned lanes,
                                               input int unsigned code);
      int unsigned nfields;
      nfields = word_w >> code;
      return (nfields + lanes - 1) / lanes;
   endfunction

endpackage

// File: rtl/unpk_seq.sv
module unpk_seq
   import unpk_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int LANES  = 4,
   parameter int CODE_W = 3,
   parameter int GRP_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   input  logic              sign_in,
   input  logic              rd_valid,
   input  logic [WORD_W-1:0] rd_data,
   output logic [WORD_W-1:0] hold_q,
   output logic [CODE_W-1:0] code_q,
   output logic              sign_q,
   output logic [GRP_W-1:0]  grp_q,
   output logic              issue,
   output logic              rd_req
);

   logic have_q;
   logic pend_q;
   logic mismatch;
   logic last_grp;
   logic load;

   assign mismatch = have_q && (code_in != code_q);
   assign issue    = have_q && !mismatch;
   assign last_grp = (grp_q == GRP_W'(unpk_groups(WORD_W, LANES, int'(code_q)) - 1));
   assign rd_req   = !pend_q && (!have_q || mismatch || last_grp);
   assign load     = pend_q && rd_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         code_q <= '0;
         sign_q <= 1'b0;
         grp_q  <= '0;
         have_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (load) begin
            hold_q <= rd_data;
            code_q <= code_in;
            sign_q <= sign_in;
            grp_q  <= '0;
            have_q <= 1'b1;
            pend_q <= 1'b0;
         end else begin
            if (rd_req) begin
               pend_q <= 1'b1;
            end
            if (mismatch || (issue && last_grp)) begin
               have_q <= 1'b0;
               grp_q  <= '0;
            end else if (issue) begin
               grp_q  <= grp_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/unpk_slice.sv
module unpk_slice #(
   parameter int WORD_W   = 32,
   parameter int LANES    = 4,
   parameter int MAX_CODE = 4,
   parameter int CODE_W   = 3,
   parameter int GRP_W    = 3,
   parameter int OUT_W    = 16
) (
   input  logic [WORD_W-1:0]       hold_q,
   input  logic [CODE_W-1:0]       code_q,
   input  logic                    sign_q,
   input  logic [GRP_W-1:0]        grp_q,
   output logic [LANES*OUT_W-1:0]  data_o,
   output logic [LANES-1:0]        valid_o
);

   localparam int NSEL = 1 << CODE_W;

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic [OUT_W-1:0] cand   [NSEL];
      logic             cvalid [NSEL];

      for (genvar s = 0; s < NSEL; s++) begin : g_sel
         localparam int CE = (s > MAX_CODE) ? MAX_CODE : s;
         localparam int W  = 1 << CE;
         localparam int NF = WORD_W >> CE;
         int               fidx;
         logic [WORD_W-1:0] shifted;
         logic [W-1:0]      fld;

         assign fidx      = int'(grp_q) * LANES + L;
         assign shifted   = hold_q >> (fidx * W);
         assign fld       = shifted[W-1:0];
         assign cvalid[s] = (fidx < NF);
         assign cand[s]   = sign_q ? OUT_W'($signed(fld)) : OUT_W'(fld);
      end

      assign valid_o[L]                 = cvalid[code_q];
      assign data_o[L*OUT_W +: OUT_W]   = cvalid[code_q] ? cand[code_q] : '0;
   end

endmodule

// File: rtl/operand_unpacker.sv
module operand_unpacker
   import unpk_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int LANES    = 4,
   parameter int MAX_CODE = 4,
   localparam int OUT_W   = 1 << MAX_CODE,
   localparam int CODE_W  = $clog2(MAX_CODE + 1),
   localparam int MAXG    = (WORD_W + LANES - 1) / LANES,
   localparam int GRP_W   = (MAXG > 1) ? $clog2(MAXG) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CODE_W-1:0]      width_sel,
   input  logic                   sign_en,
   input  logic                   rd_valid,
   input  logic [WORD_W-1:0]      rd_data,
   output logic                   rd_req,
   output logic                   out_valid,
   output logic [LANES-1:0]       lane_valid,
   output logic [LANES*OUT_W-1:0] lane_data
);

   initial begin
      cfg_word_pow2: assert ((WORD_W & (WORD_W - 1)) == 0)
         else $error("WORD_W must be a power of two");
      cfg_lanes_pow2: assert (LANES > 0 && (LANES & (LANES - 1)) == 0)
         else $error("LANES must be a power of two");
      cfg_width_fits: assert (OUT_W <= WORD_W)
         else $error("widest field exceeds the buffer word");
   end

   logic [CODE_W-1:0]      code_n;
   logic [WORD_W-1:0]      hold_q;
   logic [CODE_W-1:0]      code_q;
   logic                   sign_q;
   logic [GRP_W-1:0]       grp_q;
   logic                   issue;
   logic [LANES*OUT_W-1:0] raw_data;
   logic [LANES-1:0]       raw_valid;

   assign code_n = (int'(width_sel) > MAX_CODE) ? CODE_W'(MAX_CODE) : width_sel;

   unpk_seq #(
      .WORD_W(WORD_W), .LANES(LANES), .CODE_W(CODE_W), .GRP_W(GRP_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .code_in(code_n), .sign_in(sign_en),
      .rd_valid(rd_valid), .rd_data(rd_data), .hold_q(hold_q),
      .code_q(code_q), .sign_q(sign_q), .grp_q(grp_q),
      .issue(issue), .rd_req(rd_req)
   );

   unpk_slice #(
      .WORD_W(WORD_W), .LANES(LANES), .MAX_CODE(MAX_CODE),
      .CODE_W(CODE_W), .GRP_W(GRP_W), .OUT_W(OUT_W)
   ) u_slice (
      .hold_q(hold_q), .code_q(code_q), .sign_q(sign_q), .grp_q(grp_q),
      .data_o(raw_data), .valid_o(raw_valid)
   );

   assign out_valid  = issue;
   assign lane_valid = issue ? raw_valid : '0;

   for (genvar L = 0; L < LANES; L++) begin : g_gate
      assign lane_data[L*OUT_W +: OUT_W] =
         lane_valid[L] ? raw_data[L*OUT_W +: OUT_W] : '0;
   end

endmodule

// File: rtl/operand_unpacker_chk.sv
module operand_unpacker_chk #(
   parameter int LANES = 4,
   parameter int OUT_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rd_req,
   input logic                   rd_valid,
   input logic                   out_valid,
   input logic [LANES-1:0]       lane_valid,
   input logic [LANES*OUT_W-1:0] lane_data
);

   assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   assert_gap_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !out_valid);

   assert_issue_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(rd_valid));

   assert_quiet_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (lane_valid == '0));

   assert_lane0_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> lane_valid[0]);

   for (genvar i = 0; i < LANES; i++) begin : g_zero
      assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_valid[i] |-> (lane_data[i*OUT_W +: OUT_W] == '0));
   end

endmodule

bind operand_unpacker operand_unpacker_chk #(
   .LANES(LANES), .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
   .out_valid(out_valid), .lane_valid(lane_valid), .lane_data(lane_data)
);

// File: tb/sim_operand_unpacker.sv
`timescale 1ns/1ps
module sim_operand_unpacker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  width_sel = '0;
   logic        sign_en = 1'b0;
   logic        rd_valid = 1'b0;
   logic [31:0] rd_data = '0;
   logic        rd_req;
   logic        out_valid;
   logic [3:0]  lane_valid;
   logic [63:0] lane_data;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   operand_unpacker u0 (
      .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .sign_en(sign_en),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_req(rd_req),
      .out_valid(out_valid), .lane_valid(lane_valid), .lane_data(lane_data)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 100000) begin
         fails = fails + 1;
         $display("FAIL R6 watchdog: cycles=%0d expected below %0d", cycles, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // {out_valid, rd_req, lane_valid, lane_data}
   task automatic check(input string tag, input logic [69:0] exp);
      logic [69:0] act;
      act = {out_valid, rd_req, lane_valid, lane_data};
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [69:0] expect_grp(input logic [31:0] d, input int code,
                                              input bit sgn, input int g, input bit last);
      int cn, w, nf;
      logic [3:0]  lv;
      logic [63:0] ld;
      logic [31:0] mask, fld;
      cn = (code > 4) ? 4 : code;          // R2
      w  = 1 << cn;
      nf = 32 / w;
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      lv = '0;
      ld = '0;
      for (int lane = 0; lane < 4; lane++) begin
         int f;
         f = g * 4 + lane;                  // R3
         if (f < nf) begin                  // R4
            fld = (d >> (f * w)) & mask;
            if (sgn && fld[w-1]) fld = fld | ~mask;   // R5
            lv[lane] = 1'b1;
            ld[lane*16 +: 16] = fld[15:0];
         end
      end
      return {1'b1, last, lv, ld};
   endfunction

   // entered at a negedge where a request is raised; returns at the negedge
   // of the last issued group (or of a discard)
   task automatic serve_word(input logic [31:0] d, input int code, input bit sgn,
                             input int lat, input int dist_g,
                             input int cut_g, input int cut_code);
      int cn, ng;
      cn = (code > 4) ? 4 : code;
      ng = ((32 >> cn) + 3) / 4;
      @(negedge clk);
      width_sel = 3'(code);
      sign_en   = sgn;
      check("R6,R7 waiting", 70'b0);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         check("R7 waiting", 70'b0);
      end
      rd_valid = 1'b1;
      rd_data  = d;
      @(negedge clk);
      rd_valid = 1'b0;
      rd_data  = $urandom;
      for (int g = 0; g < ng; g++) begin
         check("R3,R4,R5,R6 issue", expect_grp(d, code, sgn, g, g == ng - 1));
         if (g == cut_g) begin
            width_sel = 3'(cut_code);
            #1;
            check("R9 discard", {1'b0, 1'b1, 68'b0});
            return;
         end
         if (g == ng - 1) return;
         if (g == dist_g) begin
            sign_en  = ~sign_en;       // R5: no effect on held word
            rd_valid = 1'b1;           // R8: unsolicited word ignored
            rd_data  = ~d;
         end
         @(negedge clk);
         rd_valid = 1'b0;
      end
   endtask

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      check("R1 in reset", {1'b0, 1'b1, 68'b0});
      rst_n = 1'b1;
      #1;
      check("R1 after reset", {1'b0, 1'b1, 68'b0});

      // directed corner cases
      serve_word(32'hFFFF_FFFF, 0, 1'b1, 0, -1, -1, 0);          // R2, R5 1-bit signed
      serve_word(32'hA5C3_0F96, 0, 1'b0, 2, 3, -1, 0);           // R8, R5 mid-word disturb
      serve_word(32'h8001_7FFF, 4, 1'b1, 1, -1, -1, 0);          // R2, R4 two lanes
      serve_word(32'h8001_7FFF, 6, 1'b0, 0, -1, -1, 0);          // R2 code 6 as 16 bits
      serve_word(32'h7F80_FF01, 3, 1'b1, 0, -1, -1, 0);          // R5 8-bit signed
      serve_word(32'h1234_5678, 2, 1'b0, 0, 0, -1, 0);           // R3 4-bit order
      serve_word(32'hDEAD_BEEF, 1, 1'b1, 3, 1, -1, 0);           // R5 2-bit signed
      serve_word(32'hCAFE_F00D, 0, 1'b0, 0, -1, 3, 3);           // R9 discard mid-word
      serve_word(32'h0F0F_F0F0, 3, 1'b1, 0, -1, -1, 0);          // R9 new width used

      // constrained random traffic
      for (int n = 0; n < 300; n++) begin
         int code, ng, dg, cg, cc;
         code = int'($urandom_range(0, 7));
         ng   = ((32 >> ((code > 4) ? 4 : code)) + 3) / 4;
         dg   = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, ng - 1)) : -1;
         cg   = -1;
         cc   = 0;
         if (ng > 1 && $urandom_range(0, 7) == 0) begin
            cg = int'($urandom_range(0, ng - 2));
            cc = (code >= 4) ? 2 : code + 1;
         end
         serve_word($urandom, code, 1'($urandom), int'($urandom_range(0, 3)), dg, cg, cc);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule